// File: doc/BRIEF.md
# Parallel Interface Control Register Bank

This block is the host-facing register bank of a 16-bit parallel word interface. A byte-wide bus reaches eight registers. They hold the interface mode, a set of latched control bits, a write-only command port, and a read-only flag and status byte. They also hold the two bytes of the data word and the three bytes of a transfer range counter. From these registers the block drives the device function lines, the direction and transfer-enable controls, and the one-cycle command strobes that go to the device and to the handshake logic.

On the device side the block takes the live status lines, the attention line, the ready line and the multicycle error indication. It also takes a strobe for each word transferred and a strobe that captures the incoming data word. Two sticky flags are kept here. The end-of-range flag sets when the range counter runs out. The attention flag sets on each rising edge of the attention line. Each flag has its own mask bit, and the masked flags feed a single interrupt line. A master-clear command resets the control state but keeps the mode register, which is cleared only by the bus reset.

Top module: `pio_regbank`

## Requirements
- R1: The bank responds only when bus_addr[15:14] is 2'b10. Address bits 6:4 pick the register. Index 0 is mode, 1 is latched controls, 2 is the command port on write and status on read, 3 is data high, 4 is data low, and 5, 6 and 7 are the range bytes high, mid and low. Writes and reads at any other address change nothing and produce no read response.
- R2: A read asserts bus_rvalid for one cycle, on the cycle after bus_rd is sampled, with bus_rdata holding the selected register. Mode and latched controls read back as they were written.
- R3: A write to index 2 raises the strobes for one cycle, starting in the cycle after the write. The bit mapping is: bit 5 to stb_term, bit 4 to stb_mclr, bit 3 to stb_init, bit 2 to stb_aux, bit 1 to stb_cycle and bit 0 to stb_go.
- R4: Status bit 6 is the attention flag. It sets on a rising edge of dev_attn. Status bit 5 shows the live dev_attn level.
- R5: Writing command bit 7 clears the end-of-range flag. Writing command bit 6 clears the attention flag.
- R6: Command bit 4 (master clear) clears the latched controls and both flags, and leaves the mode register unchanged. rst clears all registers, mode included.
- R7: Writing a range byte loads that byte of the 24-bit counter. Reads of indices 5 to 7 return the live counter bytes.
- R8: Each word_done decrements a nonzero counter by one. A word_done that arrives with the counter at zero sets the end-of-range flag (status bit 7), and the counter then stays at zero until it is reloaded.
- R9: When latched-controls bit 5 is set, word_done leaves both the counter and the end-of-range flag unchanged.
- R10: Latched-controls bits 3:1 drive fcn_out[2:0]. Bit 4 drives xfer_en and bit 0 drives dir_in, where 1 means input.
- R11: irq is high when the end-of-range flag is set with latched-controls bit 7 at 1, or when the attention flag is set with latched-controls bit 6 at 1.
- R12: Status bit 4 returns dev_mcerr, bits 3:1 return dev_status[2:0], and bit 0 returns dev_ready, where 0 means ready.
- R13: Writes to index 3 and index 4 set dout_word[15:8] and dout_word[7:0]. A pulse on din_capture latches din_word, and reads of index 3 and index 4 return the high and low bytes of that captured word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high bus reset |
| bus_addr | input | 16 | Byte address |
| bus_wr | input | 1 | Write request |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read request |
| bus_rdata | output | 8 | Registered read data |
| bus_rvalid | output | 1 | Read data valid |
| dev_status | input | 3 | Device status lines |
| dev_attn | input | 1 | Device attention line |
| dev_ready | input | 1 | Handshake ready, 0 = ready |
| dev_mcerr | input | 1 | Multicycle error indication |
| word_done | input | 1 | One word transferred |
| din_word | input | 16 | Incoming data word |
| din_capture | input | 1 | Latch din_word |
| dout_word | output | 16 | Outgoing data word |
| mode_out | output | 8 | Mode register for the handshake logic |
| fcn_out | output | 3 | Function lines to the device |
| xfer_en | output | 1 | Transfer control enable |
| dir_in | output | 1 | Direction, 1 = input |
| stb_term | output | 1 | Force ready and reset the handshake |
| stb_mclr | output | 1 | Master clear strobe |
| stb_init | output | 1 | Device init strobe |
| stb_aux | output | 1 | Auxiliary function strobe |
| stb_cycle | output | 1 | Forced cycle request |
| stb_go | output | 1 | GO strobe |
| irq | output | 1 | Masked flag interrupt |

## Verification
The bench drives the range counter through its last word and one word beyond it. A counter that wrapped would read back 0xFFFFFF, and one that set the flag one word early would report end-of-range while a word was still owed. It issues a master clear after loading the mode and control registers: a design that cleared mode on that command, or kept the attention flag through it, shows the wrong byte on readback. It holds attention high over several cycles and expects the flag to set once, and it checks that an earlier clear sticks while the level stays high. It also writes to an address outside the select window and expects no change and no read response.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int IDX_W = 3;
  localparam logic [IDX_W-1:0] IDX_MODE  = 3'd0;
  localparam logic [IDX_W-1:0] IDX_LATCH = 3'd1;
  localparam logic [IDX_W-1:0] IDX_CMD   = 3'd2;
  localparam logic [IDX_W-1:0] IDX_DHI   = 3'd3;
  localparam logic [IDX_W-1:0] IDX_DLO   = 3'd4;
  localparam logic [IDX_W-1:0] IDX_RHI   = 3'd5;
  localparam logic [IDX_W-1:0] IDX_RMID  = 3'd6;
  localparam logic [IDX_W-1:0] IDX_RLO   = 3'd7;

  // command port bit positions
  localparam int CB_CLR_EOR = 7;
  localparam int CB_CLR_ATT = 6;
  localparam int CB_MCLR    = 4;
  localparam int NSTROBE    = 6;   // bits 5..0 leave as strobes

  // latched control bit positions
  localparam int LB_EOR_MASK = 7;
  localparam int LB_ATT_MASK = 6;
  localparam int LB_CNT_OFF  = 5;
  localparam int LB_XFER_EN  = 4;
  localparam int LB_DIR_IN   = 0;
endpackage

// File: rtl/pio_ctl_regs.sv
module pio_ctl_regs
  import pio_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int WORD_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      idx,
  input  logic [BYTE_W-1:0]     wdata,
  input  logic [WORD_W-1:0]     din_word,
  input  logic                  din_capture,
  output logic [BYTE_W-1:0]     mode_q,
  output logic [BYTE_W-1:0]     latch_q,
  output logic [WORD_W-1:0]     dout_q,
  output logic [WORD_W-1:0]     din_q,
  output logic [NSTROBE-1:0]    strobe_q,
  output logic                  mclr_now,
  output logic                  clr_eor,
  output logic                  clr_att
);
  logic cmd_wr;
  assign cmd_wr   = wr_en && (idx == IDX_CMD);
  assign mclr_now = cmd_wr && wdata[CB_MCLR];
  assign clr_eor  = cmd_wr && wdata[CB_CLR_EOR];
  assign clr_att  = cmd_wr && wdata[CB_CLR_ATT];

  always_ff @(posedge clk) begin
    if (rst) mode_q <= '0;
    else if (wr_en && idx == IDX_MODE) mode_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || mclr_now) latch_q <= '0;
    else if (wr_en && idx == IDX_LATCH) latch_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) dout_q <= '0;
    else begin
      if (wr_en && idx == IDX_DHI) dout_q[BYTE_W +: BYTE_W] <= wdata;
      if (wr_en && idx == IDX_DLO) dout_q[0 +: BYTE_W]      <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) din_q <= '0;
    else if (din_capture) din_q <= din_word;
  end

  always_ff @(posedge clk) begin
    if (rst) strobe_q <= '0;
    else     strobe_q <= cmd_wr ? wdata[NSTROBE-1:0] : '0;
  end

  // R3
  go_strobe_src_chk: assert property (@(posedge clk) disable iff (rst)
    strobe_q[0] |-> $past(wr_en && idx == IDX_CMD && wdata[0]));

  // R6
  mode_keep_on_mclr_chk: assert property (@(posedge clk) disable iff (rst)
    mclr_now |=> $stable(mode_q));
endmodule

// File: rtl/pio_attn_flag.sv
module pio_attn_flag (
  input  logic clk,
  input  logic rst,
  input  logic mclr,
  input  logic clr,
  input  logic attn_in,
  output logic flag_q
);
  logic attn_d;
  logic rise;
  assign rise = attn_in && !attn_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      attn_d <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      attn_d <= attn_in;
      if (rise)             flag_q <= 1'b1;
      else if (clr || mclr) flag_q <= 1'b0;
    end
  end

  // R4
  attn_edge_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (attn_in && !attn_d) |=> flag_q);
endmodule

// File: rtl/pio_range_cnt.sv
module pio_range_cnt
  import pio_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              count_en,
  input  logic              word_done,
  input  logic              mclr,
  input  logic              clr_eor,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              eor_q
);
  localparam int NLANE = CNT_W / BYTE_W;

  logic [NLANE-1:0] lane_hit;
  logic [CNT_W-1:0] ld_val;
  logic             any_load;
  logic             step;
  logic             at_zero;

  for (genvar b = 0; b < NLANE; b++) begin : g_lane
    assign lane_hit[b] = wr_en && (idx == IDX_RLO - IDX_W'(b));
    assign ld_val[b*BYTE_W +: BYTE_W] = lane_hit[b] ? wdata : cnt_q[b*BYTE_W +: BYTE_W];
  end

  assign any_load = |lane_hit;
  assign at_zero  = (cnt_q == '0);
  assign step     = word_done && count_en && !any_load;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      eor_q <= 1'b0;
    end else begin
      if (any_load)             cnt_q <= ld_val;
      else if (step && !at_zero) cnt_q <= cnt_q - 1'b1;
      if (step && at_zero)        eor_q <= 1'b1;
      else if (clr_eor || mclr)   eor_q <= 1'b0;
    end
  end

  // R8
  hold_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (at_zero && !any_load) |=> (cnt_q == '0));
  // R8
  decrement_chk: assert property (@(posedge clk) disable iff (rst)
    (word_done && count_en && !any_load && !at_zero) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R9
  disabled_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!count_en && !any_load) |=> $stable(cnt_q));
endmodule

// File: rtl/pio_regbank.sv
module pio_regbank
  import pio_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8,
  parameter int WORD_W = 16,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [BYTE_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic [2:0]        dev_status,
  input  logic              dev_attn,
  input  logic              dev_ready,
  input  logic              dev_mcerr,
  input  logic              word_done,
  input  logic [WORD_W-1:0] din_word,
  input  logic              din_capture,
  output logic [WORD_W-1:0] dout_word,
  output logic [BYTE_W-1:0] mode_out,
  output logic [2:0]        fcn_out,
  output logic              xfer_en,
  output logic              dir_in,
  output logic              stb_term,
  output logic              stb_mclr,
  output logic              stb_init,
  output logic              stb_aux,
  output logic              stb_cycle,
  output logic              stb_go,
  output logic              irq
);
  localparam int IDX_LSB = 4;
  localparam int PAD_W   = 8 * BYTE_W;

  logic              sel, wr, rd;
  logic [IDX_W-1:0]  idx;
  logic [BYTE_W-1:0] latch_q;
  logic [WORD_W-1:0] din_q;
  logic [NSTROBE-1:0] strobe_q;
  logic              mclr_now, clr_eor, clr_att;
  logic [CNT_W-1:0]  cnt_q;
  logic              eor_q, att_q;
  logic [PAD_W-1:0]  cnt_pad;
  logic [IDX_W-1:0]  lane;
  logic [BYTE_W-1:0] rmux;

  assign sel = (bus_addr[ADDR_W-1 -: 2] == 2'b10);
  assign idx = bus_addr[IDX_LSB +: IDX_W];
  assign wr  = bus_wr && sel;
  assign rd  = bus_rd && sel;

  pio_ctl_regs #(.BYTE_W(BYTE_W), .WORD_W(WORD_W)) u_ctl (
    .clk(clk), .rst(rst), .wr_en(wr), .idx(idx), .wdata(bus_wdata),
    .din_word(din_word), .din_capture(din_capture),
    .mode_q(mode_out), .latch_q(latch_q), .dout_q(dout_word), .din_q(din_q),
    .strobe_q(strobe_q), .mclr_now(mclr_now), .clr_eor(clr_eor), .clr_att(clr_att)
  );

  pio_attn_flag u_attn (
    .clk(clk), .rst(rst), .mclr(mclr_now), .clr(clr_att),
    .attn_in(dev_attn), .flag_q(att_q)
  );

  pio_range_cnt #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .wr_en(wr), .idx(idx), .wdata(bus_wdata),
    .count_en(!latch_q[LB_CNT_OFF]), .word_done(word_done),
    .mclr(mclr_now), .clr_eor(clr_eor), .cnt_q(cnt_q), .eor_q(eor_q)
  );

  assign fcn_out   = latch_q[3:1];
  assign xfer_en   = latch_q[LB_XFER_EN];
  assign dir_in    = latch_q[LB_DIR_IN];
  assign {stb_term, stb_mclr, stb_init, stb_aux, stb_cycle, stb_go} = strobe_q;
  assign irq = (eor_q && latch_q[LB_EOR_MASK]) || (att_q && latch_q[LB_ATT_MASK]);

  assign cnt_pad = {{(PAD_W-CNT_W){1'b0}}, cnt_q};
  assign lane    = IDX_RLO - idx;

  always_comb begin
    case (idx)
      IDX_MODE:  rmux = mode_out;
      IDX_LATCH: rmux = latch_q;
      IDX_CMD:   rmux = {eor_q, att_q, dev_attn, dev_mcerr, dev_status, dev_ready};
      IDX_DHI:   rmux = din_q[BYTE_W +: BYTE_W];
      IDX_DLO:   rmux = din_q[0 +: BYTE_W];
      default:   rmux = cnt_pad[lane*BYTE_W +: BYTE_W];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd;
      if (rd) bus_rdata <= rmux;
    end
  end

  // R1
  unselected_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !sel) |=> $stable(mode_out));
  // R2
  rvalid_follows_rd_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> $past(bus_rd && sel));
  // R11
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> (eor_q || att_q));
endmodule

// File: tb/pio_regbank_test.sv
module pio_regbank_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic bus_rvalid;
  logic [2:0] dev_status = 3'b000;
  logic dev_attn = 1'b0, dev_ready = 1'b1, dev_mcerr = 1'b0;
  logic word_done = 1'b0, din_capture = 1'b0;
  logic [15:0] din_word = '0;
  logic [15:0] dout_word;
  logic [7:0] mode_out;
  logic [2:0] fcn_out;
  logic xfer_en, dir_in, stb_term, stb_mclr, stb_init, stb_aux, stb_cycle, stb_go, irq;

  int n_checks = 0;
  int n_errors = 0;
  logic [7:0] exp_val_q[$];
  string      exp_tag_q[$];

  always #4 clk = ~clk;

  pio_regbank uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .dev_status(dev_status), .dev_attn(dev_attn), .dev_ready(dev_ready), .dev_mcerr(dev_mcerr),
    .word_done(word_done), .din_word(din_word), .din_capture(din_capture),
    .dout_word(dout_word), .mode_out(mode_out), .fcn_out(fcn_out), .xfer_en(xfer_en),
    .dir_in(dir_in), .stb_term(stb_term), .stb_mclr(stb_mclr), .stb_init(stb_init),
    .stb_aux(stb_aux), .stb_cycle(stb_cycle), .stb_go(stb_go), .irq(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] reg_addr(int idx);
    return 16'h8000 | 16'(idx << 4);
  endfunction

  task automatic wr(logic [15:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // driver: push the expected byte, then issue the read
  task automatic rd(int idx, logic [7:0] exp, string tag);
    exp_val_q.push_back(exp);
    exp_tag_q.push_back(tag);
    bus_addr = reg_addr(idx); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_word();
    word_done = 1'b1;
    @(negedge clk);
    word_done = 1'b0;
  endtask

  // monitor: compare every read response against the scoreboard
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (exp_val_q.size() == 0) begin
        n_checks++; n_errors++;
        $display("FAIL R1: unexpected read response actual=%0h expected=none", bus_rdata);
      end else begin
        check(exp_tag_q.pop_front(), bus_rdata, exp_val_q.pop_front());
      end
    end
  end

  initial begin
    #(8 * 100000);
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    check("R6 reset strobes", {stb_term, stb_mclr, stb_init, stb_aux, stb_cycle, stb_go}, 0);
    check("R11 reset irq", irq, 0);
    rd(0, 8'h00, "R6 reset mode");
    rd(2, 8'h01, "R12 reset status");

    // R2 readback, R10 outputs
    wr(reg_addr(0), 8'hA5);
    wr(reg_addr(1), 8'h1B);  // fcn=101, xfer_en=1, dir_in=1
    check("R10 fcn_out", fcn_out, 3'b101);
    check("R10 xfer_en", xfer_en, 1);
    check("R10 dir_in", dir_in, 1);
    check("R2 mode_out", mode_out, 8'hA5);
    rd(0, 8'hA5, "R2 mode readback");
    rd(1, 8'h1B, "R2 latch readback");

    // R1: write outside the window is ignored, read gives no response
    wr(16'h4000, 8'h33);
    bus_addr = 16'h4000; bus_rd = 1'b1; @(negedge clk); bus_rd = 1'b0; @(negedge clk);
    rd(0, 8'hA5, "R1 mode after unselected write");

    // R3 strobes
    wr(reg_addr(2), 8'h2D);  // term, init, aux, go
    check("R3 strobes first cycle", {stb_term, stb_mclr, stb_init, stb_aux, stb_cycle, stb_go}, 6'b101101);
    @(negedge clk);
    check("R3 strobes cleared", {stb_term, stb_mclr, stb_init, stb_aux, stb_cycle, stb_go}, 0);
    wr(reg_addr(2), 8'h02);
    check("R3 cycle strobe", {stb_term, stb_mclr, stb_init, stb_aux, stb_cycle, stb_go}, 6'b000010);

    // R12 status inputs
    dev_status = 3'b110; dev_mcerr = 1'b1; dev_ready = 1'b0;
    @(negedge clk);
    rd(2, 8'h1C, "R12 status bits");
    dev_status = 3'b000; dev_mcerr = 1'b0; dev_ready = 1'b1;

    // R4 attention edge, R11 irq
    wr(reg_addr(1), 8'h40);
    dev_attn = 1'b1;
    @(negedge clk);
    check("R11 irq on attention", irq, 1);
    rd(2, 8'h61, "R4 attention flag and level");
    wr(reg_addr(2), 8'h40);   // R5 clear attention while level stays high
    @(negedge clk);
    rd(2, 8'h21, "R5 attention cleared, no re-set on level");
    check("R11 irq low after clear", irq, 0);
    dev_attn = 1'b0;
    @(negedge clk);
    dev_attn = 1'b1;
    @(negedge clk);
    dev_attn = 1'b0;
    @(negedge clk);
    rd(2, 8'h41, "R4 flag sticky after level falls");

    // R6 master clear
    wr(reg_addr(1), 8'h5E);
    wr(reg_addr(2), 8'h10);
    check("R6 mclr strobe", stb_mclr, 1);
    rd(1, 8'h00, "R6 latch cleared");
    rd(0, 8'hA5, "R6 mode survives mclr");
    rd(2, 8'h01, "R6 flags cleared");

    // R7 load and live read, R8 count down and hold
    wr(reg_addr(5), 8'h12);
    wr(reg_addr(6), 8'h34);
    wr(reg_addr(7), 8'h56);
    rd(5, 8'h12, "R7 range high");
    rd(6, 8'h34, "R7 range mid");
    rd(7, 8'h56, "R7 range low");
    wr(reg_addr(5), 8'h00);
    wr(reg_addr(6), 8'h01);
    wr(reg_addr(7), 8'h00);
    pulse_word();
    rd(6, 8'h00, "R8 borrow across bytes mid");
    rd(7, 8'hFF, "R8 borrow across bytes low");
    wr(reg_addr(6), 8'h00);
    wr(reg_addr(7), 8'h02);
    wr(reg_addr(1), 8'h80);
    pulse_word();
    pulse_word();
    rd(7, 8'h00, "R8 at zero");
    rd(2, 8'h01, "R8 no end-of-range yet");
    check("R11 irq not yet", irq, 0);
    pulse_word();
    rd(2, 8'h81, "R8 end-of-range set");
    check("R11 irq on end-of-range", irq, 1);
    pulse_word();
    rd(5, 8'h00, "R8 hold high");
    rd(7, 8'h00, "R8 hold low");
    wr(reg_addr(2), 8'h80);
    rd(2, 8'h01, "R5 end-of-range cleared");

    // R9 counter disabled
    wr(reg_addr(1), 8'h20);
    wr(reg_addr(7), 8'h05);
    pulse_word();
    pulse_word();
    rd(7, 8'h05, "R9 counter frozen");
    wr(reg_addr(7), 8'h00);
    pulse_word();
    rd(2, 8'h01, "R9 no end-of-range when disabled");

    // R13 data paths
    wr(reg_addr(3), 8'hBE);
    wr(reg_addr(4), 8'hEF);
    check("R13 dout_word", dout_word, 16'hBEEF);
    din_word = 16'h1234; din_capture = 1'b1;
    @(negedge clk);
    din_capture = 1'b0; din_word = 16'hFFFF;
    rd(3, 8'h12, "R13 captured high");
    rd(4, 8'h34, "R13 captured low");

    repeat (3) @(negedge clk);
    check("R2 all reads answered", exp_val_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule